// File: doc/BRIEF.md
# TDM Serial Port Channel Interface

This block sits between a 2.048 Mbit/s time-division serial bus and a set of per-frame byte registers inside a line transceiver. A frame holds 32 eight-bit channels. The block runs on the bus bit clock at twice the bit rate, so each bit cell lasts two clocks. An active-low frame pulse aligns the frame. Two serial lanes are served: a data/voice lane that carries the B bytes, and a control/data lane that carries the C and D bytes. The bytes taken from the bus are gathered during the frame and handed to the line side at the next frame boundary. The bytes the line side presents are latched at that same boundary and sent out during the following frame.

The channel map depends on three mode inputs: dual-port or single-port, 80 or 160 kbit/s line rate, and C-first or D-first ordering on the control/data lane. The block drives each serial output only in its own channel times and signals high impedance through an output enable in every other slot. An output-disable input keeps both outputs released at all times, for power-up on a shared bus. The block also sends an active-low chain pulse at the end of its active channels, so that the next device on the same bus can start its own channels there.

Top module: `tdm_chan_port`

## Requirements
- R1: The cycle after `frame_n` is sampled low is the first clock of channel 0. A frame has 512 clocks, 32 channels of 8 bits, 2 clocks per bit, and bytes go most significant bit first. An output bit changes only on the first clock of a bit cell, and an input bit is sampled at the end of the second clock of the cell.
- R2: In dual-port mode the data/voice lane carries B1 in channel 0, and carries B2 in channel 16 only when `rate_hi`=1.
- R3: In dual-port mode the control/data lane uses channels 0 and 16. With `c_first`=1, C goes in channel 0 and D in channel 16. With `c_first`=0 the order is swapped.
- R4: In single-port mode the data/voice lane carries D in channel 0, C in channel 1, B1 in channel 2 and, when `rate_hi`=1, B2 in channel 3. The control/data lane is never driven, and `cd_in` has no effect on any captured byte.
- R5: An output enable is high only in a channel that the current mode assigns to that lane. Both enables stay low from reset until the first frame pulse.
- R6: While `out_dis`=1, both `dv_oe` and `cd_oe` are low in every slot.
- R7: `fpo_n` is low for exactly one clock, the last clock of the block's last active channel. That is clock 15 in dual-port mode, clock 47 in single-port mode at 80 kbit/s, and clock 63 in single-port mode at 160 kbit/s.
- R8: Bytes received from the bus appear on `up_*` at the frame-pulse edge and hold steady for the whole next frame. A byte that the mode did not carry in a frame keeps its earlier value (for example B2 at 80 kbit/s).
- R9: The `dn_*` bytes are latched at the frame-pulse edge. Changing them during a frame does not alter what that frame sends.
- R10: While reset is held, both enables are low, `fpo_n` is high and all `up_*` bytes are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus bit clock (two clocks per bit cell) |
| rst | input | 1 | Synchronous active-high reset |
| frame_n | input | 1 | Active-low frame pulse, one clock wide |
| single_port | input | 1 | 1: all bytes on the data/voice lane |
| c_first | input | 1 | Dual-port order: 1 puts C in channel 0 |
| rate_hi | input | 1 | 1: 160 kbit/s line rate (B2 present) |
| out_dis | input | 1 | 1: both serial outputs released |
| dv_in | input | 1 | Data/voice serial input |
| cd_in | input | 1 | Control/data serial input |
| dv_out | output | 1 | Data/voice serial output data |
| dv_oe | output | 1 | Drive enable for dv_out, low means high impedance |
| cd_out | output | 1 | Control/data serial output data |
| cd_oe | output | 1 | Drive enable for cd_out, low means high impedance |
| fpo_n | output | 1 | Active-low chain pulse for the next device |
| dn_b1 | input | 8 | B1 byte to send on the bus |
| dn_b2 | input | 8 | B2 byte to send on the bus |
| dn_c | input | 8 | C byte to send on the bus |
| dn_d | input | 8 | D byte to send on the bus |
| up_b1 | output | 8 | B1 byte received from the bus |
| up_b2 | output | 8 | B2 byte received from the bus |
| up_c | output | 8 | C byte received from the bus |
| up_d | output | 8 | D byte received from the bus |

## Verification
The bench walks through every combination of port mode, rate and order, and then runs random frames. In every frame it changes the `dn_*` bytes halfway through and feeds random bits into unused channels and into the idle control/data lane. A design that tests the wrong channel, or whose lookahead is one clock off, sends bits shifted by one cell or opens its enable in a foreign slot. A design without a true second buffer either sends the mid-frame byte change at once or lets `up_*` move during the frame. Frames at 80 kbit/s check that B2 keeps its old value, single-port frames check that `cd_in` is ignored, and the idle period before the first pulse catches a design that drives before it has synced.

// File: rtl/tdm_pkg.sv
package tdm_pkg;

    localparam int BYTE_W     = 8;
    localparam int NUM_CH     = 32;
    localparam int CK_PER_BIT = 2;
    localparam int NUM_SLOT   = 4;
    localparam int CNT_PER_CH = BYTE_W * CK_PER_BIT;
    localparam int FRAME_CK   = NUM_CH * CNT_PER_CH;
    localparam int CNT_W      = $clog2(FRAME_CK);
    localparam int CH_W       = $clog2(NUM_CH);
    localparam int BIT_W      = $clog2(BYTE_W);
    localparam int SLOT_W     = $clog2(NUM_SLOT);
    localparam int HALF_CH    = NUM_CH / 2;

    localparam int PORT_DV    = 0;
    localparam int PORT_CD    = 1;

    // channel positions in single-port mode (order is behaviour)
    localparam int SGL_D_CH   = 0;
    localparam int SGL_C_CH   = 1;
    localparam int SGL_B1_CH  = 2;
    localparam int SGL_B2_CH  = 3;

    typedef enum logic [SLOT_W:0] {
        SL_B1   = 0,
        SL_B2   = 1,
        SL_C    = 2,
        SL_D    = 3,
        SL_NONE = 4
    } slot_e;

    typedef struct packed {
        logic single;
        logic c_first;
        logic rate_hi;
        logic out_dis;
    } mode_t;

    typedef logic [NUM_SLOT-1:0][BYTE_W-1:0] quad_t;

    function automatic logic [CH_W-1:0] ch_of(input logic [CNT_W-1:0] c);
        return CH_W'(int'(c) / CNT_PER_CH);
    endfunction

    function automatic logic [BIT_W-1:0] bit_of(input logic [CNT_W-1:0] c);
        return BIT_W'((BYTE_W - 1) - ((int'(c) / CK_PER_BIT) % BYTE_W));
    endfunction

    function automatic logic first_ck(input logic [CNT_W-1:0] c);
        return (int'(c) % CK_PER_BIT) == 0;
    endfunction

    function automatic logic last_ck(input logic [CNT_W-1:0] c);
        return (int'(c) % CK_PER_BIT) == (CK_PER_BIT - 1);
    endfunction

    function automatic slot_e slot_of(input int port, input logic [CH_W-1:0] ch, input mode_t m);
        slot_e s;
        int    c;
        s = SL_NONE;
        c = int'(ch);
        if (port == PORT_DV) begin
            if (m.single) begin
                if (c == SGL_D_CH)                    s = SL_D;
                else if (c == SGL_C_CH)               s = SL_C;
                else if (c == SGL_B1_CH)              s = SL_B1;
                else if (c == SGL_B2_CH && m.rate_hi) s = SL_B2;
            end else begin
                if (c == 0)                           s = SL_B1;
                else if (c == HALF_CH && m.rate_hi)   s = SL_B2;
            end
        end else if (!m.single) begin
            if (c == 0)            s = m.c_first ? SL_C : SL_D;
            else if (c == HALF_CH) s = m.c_first ? SL_D : SL_C;
        end
        return s;
    endfunction

    function automatic logic [CNT_W-1:0] end_cnt(input mode_t m);
        int last;
        last = m.single ? (m.rate_hi ? SGL_B2_CH : SGL_B1_CH) : 0;
        return CNT_W'((last + 1) * CNT_PER_CH - 1);
    endfunction

endpackage

// File: rtl/tdm_timing.sv
module tdm_timing
    import tdm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_n,
    input  mode_t            mode,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] nxt,
    output logic             synced,
    output logic             live_nxt,
    output logic             frame_edge,
    output logic             fpo_n
);

    assign frame_edge = !frame_n;
    assign nxt        = frame_edge ? '0 : CNT_W'(cnt + 1'b1);
    assign live_nxt   = synced | frame_edge;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            synced <= 1'b0;
            fpo_n  <= 1'b1;
        end else begin
            cnt    <= nxt;
            synced <= live_nxt;
            fpo_n  <= !(live_nxt && (nxt == end_cnt(mode)));
        end
    end

endmodule

// File: rtl/tdm_lane.sv
module tdm_lane
    import tdm_pkg::*;
#(
    parameter int PORT_ID = PORT_DV
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [CNT_W-1:0]  nxt,
    input  logic              synced,
    input  logic              live_nxt,
    input  mode_t             mode,
    input  quad_t             src,
    input  logic              ser_in,
    output logic              ser_out,
    output logic              oe,
    output logic              wr_en,
    output logic [SLOT_W-1:0] wr_slot,
    output logic [BIT_W-1:0]  wr_bit,
    output logic              wr_val
);

    logic [SLOT_W:0] slot_now;
    logic [SLOT_W:0] slot_nxt;
    logic            drive_nxt;
    logic            mid_cell;

    always_comb begin
        slot_now  = slot_of(PORT_ID, ch_of(cnt), mode);
        slot_nxt  = slot_of(PORT_ID, ch_of(nxt), mode);
        drive_nxt = live_nxt && (slot_nxt != SL_NONE) && !mode.out_dis;
    end

    // capture side: bit is taken at the end of the cell's last clock
    assign wr_en    = synced && last_ck(cnt) && (slot_now != SL_NONE);
    assign wr_slot  = slot_now[SLOT_W-1:0];
    assign wr_bit   = bit_of(cnt);
    assign wr_val   = ser_in;
    assign mid_cell = !first_ck(cnt);

    // launch side: registered from the lookahead count
    always_ff @(posedge clk) begin
        if (rst) begin
            oe      <= 1'b0;
            ser_out <= 1'b0;
        end else begin
            oe      <= drive_nxt;
            ser_out <= drive_nxt ? src[slot_nxt[SLOT_W-1:0]][bit_of(nxt)] : 1'b0;
        end
    end

    // R1: outputs move only at the start of a bit cell
    assert_cell_stable_R1: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && mid_cell) |-> ($stable(ser_out) && $stable(oe)));

endmodule

// File: rtl/tdm_bank.sv
module tdm_bank
    import tdm_pkg::*;
#(
    parameter int N_LANE = 2
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           frame_edge,
    input  logic [N_LANE-1:0]              wr_en,
    input  logic [N_LANE-1:0][SLOT_W-1:0]  wr_slot,
    input  logic [N_LANE-1:0][BIT_W-1:0]   wr_bit,
    input  logic [N_LANE-1:0]              wr_val,
    input  quad_t                          dn,
    output quad_t                          up,
    output quad_t                          src
);

    quad_t cap;
    quad_t hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap  <= '0;
            hold <= '0;
            up   <= '0;
        end else begin
            for (int l = 0; l < N_LANE; l++) begin
                if (wr_en[l]) cap[wr_slot[l]][wr_bit[l]] <= wr_val[l];
            end
            if (frame_edge) begin
                up   <= cap;
                hold <= dn;
            end
        end
    end

    // the frame's first bit leaves at the boundary edge itself
    assign src = frame_edge ? dn : hold;

    // R8: line-side bytes only move at a frame boundary
    assert_up_steady_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(frame_edge)) |-> $stable(up));

endmodule

// File: rtl/tdm_chan_port.sv
module tdm_chan_port
    import tdm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       frame_n,
    input  logic       single_port,
    input  logic       c_first,
    input  logic       rate_hi,
    input  logic       out_dis,
    input  logic       dv_in,
    input  logic       cd_in,
    output logic       dv_out,
    output logic       dv_oe,
    output logic       cd_out,
    output logic       cd_oe,
    output logic       fpo_n,
    input  logic [7:0] dn_b1,
    input  logic [7:0] dn_b2,
    input  logic [7:0] dn_c,
    input  logic [7:0] dn_d,
    output logic [7:0] up_b1,
    output logic [7:0] up_b2,
    output logic [7:0] up_c,
    output logic [7:0] up_d
);

    localparam int NUM_LANE = 2;

    mode_t            mode;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] nxt;
    logic             synced;
    logic             live_nxt;
    logic             frame_edge;
    quad_t            dn_q;
    quad_t            up_q;
    quad_t            src_q;

    logic [NUM_LANE-1:0]             ser_in;
    logic [NUM_LANE-1:0]             ser_out;
    logic [NUM_LANE-1:0]             oe;
    logic [NUM_LANE-1:0]             wr_en;
    logic [NUM_LANE-1:0][SLOT_W-1:0] wr_slot;
    logic [NUM_LANE-1:0][BIT_W-1:0]  wr_bit;
    logic [NUM_LANE-1:0]             wr_val;

    assign mode.single  = single_port;
    assign mode.c_first = c_first;
    assign mode.rate_hi = rate_hi;
    assign mode.out_dis = out_dis;

    assign dn_q[SL_B1] = dn_b1;
    assign dn_q[SL_B2] = dn_b2;
    assign dn_q[SL_C]  = dn_c;
    assign dn_q[SL_D]  = dn_d;
    assign up_b1 = up_q[SL_B1];
    assign up_b2 = up_q[SL_B2];
    assign up_c  = up_q[SL_C];
    assign up_d  = up_q[SL_D];

    assign ser_in[PORT_DV] = dv_in;
    assign ser_in[PORT_CD] = cd_in;
    assign dv_out = ser_out[PORT_DV];
    assign dv_oe  = oe[PORT_DV];
    assign cd_out = ser_out[PORT_CD];
    assign cd_oe  = oe[PORT_CD];

    tdm_timing u_timing (
        .clk        (clk),
        .rst        (rst),
        .frame_n    (frame_n),
        .mode       (mode),
        .cnt        (cnt),
        .nxt        (nxt),
        .synced     (synced),
        .live_nxt   (live_nxt),
        .frame_edge (frame_edge),
        .fpo_n      (fpo_n)
    );

    for (genvar g = 0; g < NUM_LANE; g++) begin : g_lane
        tdm_lane #(.PORT_ID(g)) u_lane (
            .clk      (clk),
            .rst      (rst),
            .cnt      (cnt),
            .nxt      (nxt),
            .synced   (synced),
            .live_nxt (live_nxt),
            .mode     (mode),
            .src      (src_q),
            .ser_in   (ser_in[g]),
            .ser_out  (ser_out[g]),
            .oe       (oe[g]),
            .wr_en    (wr_en[g]),
            .wr_slot  (wr_slot[g]),
            .wr_bit   (wr_bit[g]),
            .wr_val   (wr_val[g])
        );
    end

    tdm_bank #(.N_LANE(NUM_LANE)) u_bank (
        .clk        (clk),
        .rst        (rst),
        .frame_edge (frame_edge),
        .wr_en      (wr_en),
        .wr_slot    (wr_slot),
        .wr_bit     (wr_bit),
        .wr_val     (wr_val),
        .dn         (dn_q),
        .up         (up_q),
        .src        (src_q)
    );

    // R4: control/data lane is silent in single-port mode
    assert_cd_idle_single_R4: assert property (@(posedge clk) disable iff (rst)
        $past(single_port) |-> !cd_oe);

    // R6: output disable releases both lanes
    assert_quiet_disabled_R6: assert property (@(posedge clk) disable iff (rst)
        $past(out_dis) |-> (!dv_oe && !cd_oe));

    // R7: chain pulse is one clock wide
    assert_fpo_width_R7: assert property (@(posedge clk) disable iff (rst)
        !fpo_n |=> fpo_n);

endmodule

// File: tb/tdm_chan_port_tb.sv
module tdm_chan_port_tb;

    localparam int NF = 40;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst, frame_n, single_port, c_first, rate_hi, out_dis, dv_in, cd_in;
    logic       dv_out, dv_oe, cd_out, cd_oe, fpo_n;
    logic [7:0] dn_b1, dn_b2, dn_c, dn_d, up_b1, up_b2, up_c, up_d;

    tdm_chan_port u_dut (
        .clk(clk), .rst(rst), .frame_n(frame_n), .single_port(single_port),
        .c_first(c_first), .rate_hi(rate_hi), .out_dis(out_dis),
        .dv_in(dv_in), .cd_in(cd_in), .dv_out(dv_out), .dv_oe(dv_oe),
        .cd_out(cd_out), .cd_oe(cd_oe), .fpo_n(fpo_n),
        .dn_b1(dn_b1), .dn_b2(dn_b2), .dn_c(dn_c), .dn_d(dn_d),
        .up_b1(up_b1), .up_b2(up_b2), .up_c(up_c), .up_d(up_d)
    );

    int checks = 0;
    int failures = 0;
    bit done = 0;

    bit m_sg [NF];
    bit m_cf [NF];
    bit m_hi [NF];
    bit m_od [NF];

    logic [7:0] exp_cap [4];
    logic [7:0] exp_up  [4];
    logic [7:0] cur_dn  [4];
    logic [7:0] nxt_dn  [4];

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // slot codes: 0 B1, 1 B2, 2 C, 3 D, -1 unused
    function automatic int bslot(int port, int ch, bit sg, bit cf, bit hi);
        if (port == 0) begin
            if (sg) begin
                if (ch == 0) return 3;
                if (ch == 1) return 2;
                if (ch == 2) return 0;
                if (ch == 3 && hi) return 1;
                return -1;
            end
            if (ch == 0) return 0;
            if (ch == 16 && hi) return 1;
            return -1;
        end
        if (sg) return -1;
        if (ch == 0)  return cf ? 2 : 3;
        if (ch == 16) return cf ? 3 : 2;
        return -1;
    endfunction

    function automatic int fpo_end(bit sg, bit hi);
        return sg ? (hi ? 63 : 47) : 15;
    endfunction

    task automatic put_dn(input logic [7:0] v [4]);
        dn_b1 = v[0]; dn_b2 = v[1]; dn_c = v[2]; dn_d = v[3];
    endtask

    task automatic apply_mode(input int f);
        single_port = m_sg[f]; c_first = m_cf[f]; rate_hi = m_hi[f]; out_dis = m_od[f];
    endtask

    task automatic chk_up(input string tag);
        chk(tag, "up_b1", up_b1, exp_up[0]);
        chk(tag, "up_b2", up_b2, exp_up[1]);
        chk(tag, "up_c",  up_c,  exp_up[2]);
        chk(tag, "up_d",  up_d,  exp_up[3]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        bit sg, cf, hi, od, prev_sg;
        bit dv_bit, cd_bit;
        void'($urandom(32'h5EED0042));
        for (int f = 0; f < NF; f++) begin
            if (f < 8) begin
                m_sg[f] = f[2]; m_hi[f] = f[1]; m_cf[f] = f[0]; m_od[f] = 1'b0;
            end else if (f == 8) begin
                m_sg[f] = 1'b0; m_hi[f] = 1'b1; m_cf[f] = 1'b1; m_od[f] = 1'b1;
            end else begin
                m_sg[f] = 1'($urandom); m_hi[f] = 1'($urandom);
                m_cf[f] = 1'($urandom); m_od[f] = ($urandom % 8) == 0;
            end
        end
        for (int i = 0; i < 4; i++) begin
            exp_cap[i] = 8'h00; exp_up[i] = 8'h00; cur_dn[i] = 8'($urandom);
        end

        rst = 1'b1; frame_n = 1'b1; dv_in = 1'b0; cd_in = 1'b0;
        single_port = 1'b0; c_first = 1'b0; rate_hi = 1'b0; out_dis = 1'b0;
        dn_b1 = 8'hA5; dn_b2 = 8'h5A; dn_c = 8'hFF; dn_d = 8'h81;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R10", "dv_oe", dv_oe, 0);
        chk("R10", "cd_oe", cd_oe, 0);
        chk("R10", "fpo_n", fpo_n, 1);
        chk_up("R10");
        @(posedge clk); #1 rst = 1'b0;

        // no drive before the first frame pulse
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            chk("R5", "dv_oe idle", dv_oe, 0);
            chk("R5", "cd_oe idle", cd_oe, 0);
            chk("R5", "fpo_n idle", fpo_n, 1);
        end

        @(posedge clk); #1;
        frame_n = 1'b0;
        apply_mode(0);
        put_dn(cur_dn);
        prev_sg = 1'b0;
        dv_bit = 1'b0; cd_bit = 1'b0;

        for (int f = 0; f < NF; f++) begin
            sg = m_sg[f]; cf = m_cf[f]; hi = m_hi[f]; od = m_od[f];
            for (int i = 0; i < 4; i++) nxt_dn[i] = 8'($urandom);
            for (int t = 0; t < 512; t++) begin
                int ch, bt, sd, sc;
                bit eoe;
                string dtag, ctag, btag;
                ch = t / 16;
                bt = 7 - ((t / 2) % 8);
                sd = bslot(0, ch, sg, cf, hi);
                sc = bslot(1, ch, sg, cf, hi);
                @(posedge clk); #1;
                if (t == 0) frame_n = 1'b1;
                if (t % 2 == 0) begin
                    dv_bit = 1'($urandom);
                    cd_bit = 1'($urandom);
                end
                dv_in = dv_bit;
                cd_in = cd_bit;
                if (t == 200) put_dn(nxt_dn);
                if (t == 511) begin
                    frame_n = 1'b0;
                    if (f + 1 < NF) apply_mode(f + 1);
                end
                @(negedge clk);
                dtag = od ? "R6" : (sg ? "R4" : "R2");
                ctag = od ? "R6" : (sg ? "R4" : "R3");
                btag = (t > 200) ? "R9" : "R1";
                eoe = (sd >= 0) && !od;
                chk({"R5/", dtag}, "dv_oe", dv_oe, eoe);
                if (eoe) chk({btag, "/", dtag}, "dv_out", dv_out, cur_dn[sd][bt]);
                eoe = (sc >= 0) && !od;
                chk({"R5/", ctag}, "cd_oe", cd_oe, eoe);
                if (eoe) chk({btag, "/", ctag}, "cd_out", cd_out, cur_dn[sc][bt]);
                chk("R7", "fpo_n", fpo_n, (t == fpo_end(sg, hi)) ? 0 : 1);
                if (t == 0 || t == 300) chk_up(prev_sg ? "R4/R8" : "R8");
                if (t % 2 == 1) begin
                    if (sd >= 0) exp_cap[sd][bt] = dv_bit;
                    if (sc >= 0) exp_cap[sc][bt] = cd_bit;
                end
            end
            for (int i = 0; i < 4; i++) begin
                exp_up[i] = exp_cap[i];
                cur_dn[i] = nxt_dn[i];
            end
            prev_sg = sg;
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule